// File: doc/BRIEF.md
# Dual Supply Power Sequencing Reset Controller

This block decides when a system may leave reset and when it must be warned of a coming power loss. It watches two supplies. The first is the local regulated supply, which has an on-threshold and a lower off-threshold. The second is a monitored input, usually the unregulated side ahead of the regulator, which has high, low and reset thresholds. Analog comparators outside the block produce one flag per threshold. The block synchronizes each flag, filters it, and runs a five-state sequencer from the filtered values.

The block has three outputs. `save_n` is an active-low early warning, so software can store its state before power is lost. `wd_en` lets a companion watchdog run once the power-on delay has ended. `reset_n` is an active-low reset that combines the power-on delay with the watchdog's own reset request. A drop of the monitored input below its reset threshold takes priority over the watchdog. Recovery then needs a complete new power-up sequence.

Top module: `pwr_seq_rst`

## Requirements
- R1: After reset, and for as long as the debounced on-threshold flag of the local supply is low, `reset_n`, `save_n` and `wd_en` are all 0. The monitored-input flags have no effect in this condition.
- R2: A power-up sequence starts only when both the local supply on-flag and the input high-flag are 1. Either flag may become 1 first. When the supply flag comes last, `save_n` rises DEB_CYC+4 cycles after the raw flag rises. When the input flag comes last, `save_n` rises DEB_CYC+3 cycles after the raw flag rises.
- R3: `reset_n` and `wd_en` rise exactly TIMEOUT_CYC cycles after `save_n` rises at the start of a power-up sequence.
- R4: During the power-on delay, `wd_en` is 0 and `wd_rst_req` has no effect on `reset_n`. After the delay, `wd_en` is 1.
- R5: While `wd_en` is 1, `reset_n` equals the inverse of `wd_rst_req` in the same cycle.
- R6: If the input low-flag falls while the reset-flag stays 1, `save_n` goes to 0 and `reset_n` and `wd_en` stay 1. `save_n` returns to 1 only when the high-flag is 1 again; the low-flag returning alone is not enough. No new power-on delay is started.
- R7: If the input reset-flag falls after a power-up sequence has started, `reset_n`, `save_n` and `wd_en` all go to 0. This applies even when `wd_rst_req` is active. `reset_n` stays 0 until the high-flag returns and a full TIMEOUT_CYC delay completes again.
- R8: If the off-threshold flag of the local supply falls, all three outputs go to 0 from any state. A new sequence then needs the on-flag again; the off-flag returning alone is not enough.
- R9: A flag change takes effect only after the synchronized value has differed from the filtered value for DEB_CYC = TIMEOUT_CYC/32 consecutive cycles. A pulse of DEB_CYC-1 cycles has no effect. A drop of the reset-flag while in the run state pulls `reset_n` low DEB_CYC+3 cycles after the raw change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_on_raw | input | 1 | Local supply above on-threshold (asynchronous) |
| sup_hold_raw | input | 1 | Local supply above off-threshold (asynchronous) |
| in_high_raw | input | 1 | Monitored input above high threshold (asynchronous) |
| in_low_raw | input | 1 | Monitored input above low threshold (asynchronous) |
| in_rst_raw | input | 1 | Monitored input above reset threshold (asynchronous) |
| wd_rst_req | input | 1 | Reset request from the watchdog, synchronous, active high |
| reset_n | output | 1 | Combined reset, active low |
| save_n | output | 1 | Power-fail warning, active low |
| wd_en | output | 1 | Watchdog run enable |

## Verification
The watchdog reset request and a fall of the monitored input below its reset threshold can reach `reset_n` in the same cycle. The bench provokes this by holding `wd_rst_req` high in the run state and then dropping the reset-flag. It then releases the request and checks that `reset_n` stays low, because the power-fail path has taken over. The bench also pulses `wd_rst_req` during the power-on delay, where it must have no effect, and it checks that a dip to the low threshold alone never restarts that delay.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_WAIT_IN = 3'd1,
    ST_POR     = 3'd2,
    ST_RUN     = 3'd3,
    ST_FAIL    = 3'd4
  } seq_state_e;

  localparam int NFLAG       = 5;
  localparam int FL_SUP_ON   = 0;
  localparam int FL_SUP_HOLD = 1;
  localparam int FL_IN_HI    = 2;
  localparam int FL_IN_LO    = 3;
  localparam int FL_IN_RST   = 4;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/flag_debounce.sv
module flag_debounce #(
  parameter int DEB_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic level_out
);
  localparam int CW = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic          differs;

  assign differs = (level_in != lvl_q);

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (!differs) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
      lvl_d = level_in;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign level_out = lvl_q;
endmodule

// File: rtl/por_timer.sv
module por_timer #(
  parameter int TIMEOUT_CYC = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int TW = $clog2(TIMEOUT_CYC);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/pwr_seq_rst.sv
module pwr_seq_rst
  import pwr_seq_pkg::*;
#(
  parameter int TIMEOUT_CYC = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_on_raw,
  input  logic sup_hold_raw,
  input  logic in_high_raw,
  input  logic in_low_raw,
  input  logic in_rst_raw,
  input  logic wd_rst_req,
  output logic reset_n,
  output logic save_n,
  output logic wd_en
);
  localparam int DEB_CYC = (TIMEOUT_CYC / 32 > 1) ? TIMEOUT_CYC / 32 : 2;

  logic [NFLAG-1:0] raw_flags, sync_flags, deb_flags;
  seq_state_e       state_q, state_d;
  logic             save_ok_q, save_ok_d;
  logic             por_done;

  assign raw_flags[FL_SUP_ON]   = sup_on_raw;
  assign raw_flags[FL_SUP_HOLD] = sup_hold_raw;
  assign raw_flags[FL_IN_HI]    = in_high_raw;
  assign raw_flags[FL_IN_LO]    = in_low_raw;
  assign raw_flags[FL_IN_RST]   = in_rst_raw;

  flag_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (raw_flags),
    .sync_out (sync_flags)
  );

  for (genvar g = 0; g < NFLAG; g++) begin : g_deb
    flag_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
      .clk       (clk),
      .rst_n     (rst_n),
      .level_in  (sync_flags[g]),
      .level_out (deb_flags[g])
    );
  end

  por_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q == ST_POR),
    .done  (por_done)
  );

  logic sup_on, sup_hold, in_hi, in_lo, in_ok;
  assign sup_on   = deb_flags[FL_SUP_ON];
  assign sup_hold = deb_flags[FL_SUP_HOLD];
  assign in_hi    = deb_flags[FL_IN_HI];
  assign in_lo    = deb_flags[FL_IN_LO];
  assign in_ok    = deb_flags[FL_IN_RST];

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:     if (sup_on && sup_hold) state_d = ST_WAIT_IN;
      ST_WAIT_IN: if (in_hi)              state_d = ST_POR;
      ST_POR: begin
        if (!in_ok)        state_d = ST_FAIL;
        else if (por_done) state_d = ST_RUN;
      end
      ST_RUN:     if (!in_ok)             state_d = ST_FAIL;
      ST_FAIL:    if (in_hi)              state_d = ST_POR;
      default:                            state_d = ST_OFF;
    endcase
    if (state_q != ST_OFF && !sup_hold) state_d = ST_OFF;
  end

  // warning flag: set on high threshold, cleared on low threshold
  always_comb begin
    save_ok_d = 1'b0;
    if (state_d == ST_POR || state_d == ST_RUN) begin
      if (state_q != ST_POR && state_q != ST_RUN) save_ok_d = 1'b1;
      else if (!in_lo)                            save_ok_d = 1'b0;
      else if (in_hi)                             save_ok_d = 1'b1;
      else                                        save_ok_d = save_ok_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_OFF;
      save_ok_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      save_ok_q <= save_ok_d;
    end
  end

  assign wd_en   = (state_q == ST_RUN);
  assign reset_n = wd_en && !wd_rst_req;
  assign save_n  = (state_q == ST_POR || state_q == ST_RUN) && save_ok_q;
endmodule

// File: rtl/pwr_seq_rst_chk.sv
module pwr_seq_rst_chk
  import pwr_seq_pkg::*;
#(
  parameter int TIMEOUT_CYC = 256
) (
  input logic       clk,
  input logic       rst_n,
  input seq_state_e state,
  input logic       f_hold,
  input logic       f_hi,
  input logic       f_ok,
  input logic       wd_rst_req,
  input logic       reset_n,
  input logic       save_n,
  input logic       wd_en
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  logic [CW-1:0] por_cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                por_cyc_q <= '0;
    else if (state == ST_POR)  por_cyc_q <= por_cyc_q + 1'b1;
    else                       por_cyc_q <= '0;
  end

  // R4
  no_reset_release_without_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |-> !reset_n);

  // R5
  wd_request_wins_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_en && wd_rst_req) |-> !reset_n);

  // R3
  por_delay_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_en) |-> (por_cyc_q == CW'(TIMEOUT_CYC)));

  // R6
  save_release_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(save_n) |-> $past(f_hi));

  // R7
  fail_overrides_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !f_ok && f_hold) |=> (!reset_n && !save_n && !wd_en));

  // R8
  supply_loss_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !f_hold |=> (!reset_n && !save_n && !wd_en));
endmodule

bind pwr_seq_rst pwr_seq_rst_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .state      (state_q),
  .f_hold     (deb_flags[pwr_seq_pkg::FL_SUP_HOLD]),
  .f_hi       (deb_flags[pwr_seq_pkg::FL_IN_HI]),
  .f_ok       (deb_flags[pwr_seq_pkg::FL_IN_RST]),
  .wd_rst_req (wd_rst_req),
  .reset_n    (reset_n),
  .save_n     (save_n),
  .wd_en      (wd_en)
);

// File: tb/pwr_seq_rst_bench.sv
module pwr_seq_rst_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT    = 256;
  localparam int DEB        = TIMEOUT / 32;
  localparam int SETTLE     = DEB + 8;

  logic clk = 1'b0;
  logic rst_n;
  logic sup_on, sup_hold, in_hi, in_lo, in_ok, wd_req;
  logic reset_n, save_n, wd_en;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwr_seq_rst #(.TIMEOUT_CYC(TIMEOUT)) u_pwr_seq_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .sup_on_raw   (sup_on),
    .sup_hold_raw (sup_hold),
    .in_high_raw  (in_hi),
    .in_low_raw   (in_lo),
    .in_rst_raw   (in_ok),
    .wd_rst_req   (wd_req),
    .reset_n      (reset_n),
    .save_n       (save_n),
    .wd_en        (wd_en)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {reset_n, save_n, wd_en};
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts negedges until the chosen output reaches val; sel 0=reset_n 1=save_n
  task automatic count_until(input int sel, input logic val, input int maxc, output int n);
    n = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      n++;
      if ((sel == 0 ? reset_n : save_n) == val) return;
    end
    n = -1;
  endtask

  task automatic t_reset_state();
    check("R1 outputs after reset", outs(), 0);
    sup_hold = 1; in_hi = 1; in_lo = 1; in_ok = 1;
    wait_cyc(SETTLE);
    check("R1 input good, supply not on", outs(), 0);
  endtask

  task automatic t_powerup_supply_last();
    int n;
    sup_on = 1;
    count_until(1, 1'b1, 100, n);
    check("R2 save rise latency, supply last", n, DEB + 4);
    check("R4 reset held at delay start", {reset_n, wd_en}, 0);
    wait_cyc(20);
    wd_req = 1;
    wait_cyc(10);
    check("R4 wd request ignored in delay", {reset_n, wd_en}, 0);
    wd_req = 0;
    count_until(0, 1'b1, TIMEOUT + 50, n);
    check("R3 power-on delay length", n + 30, TIMEOUT);
    check("R4 watchdog enabled after delay", outs(), 7);
  endtask

  task automatic t_wd_request();
    wd_req = 1;
    #1;
    check("R5 wd request pulls reset", {reset_n, save_n, wd_en}, 3);
    @(negedge clk);
    wd_req = 0;
    #1;
    check("R5 reset released with request", outs(), 7);
  endtask

  task automatic t_low_dip();
    int lost = 0;
    in_hi = 0; in_lo = 0;
    for (int i = 0; i < SETTLE; i++) begin @(negedge clk); if (!reset_n) lost = 1; end
    check("R6 save low on low-threshold dip", outs(), 5);
    in_lo = 1;
    for (int i = 0; i < SETTLE; i++) begin @(negedge clk); if (!reset_n) lost = 1; end
    check("R6 low flag back alone keeps warning", outs(), 5);
    in_hi = 1;
    for (int i = 0; i < SETTLE; i++) begin @(negedge clk); if (!reset_n) lost = 1; end
    check("R6 warning cleared on high flag", outs(), 7);
    check("R6 no new power-on delay", lost, 0);
  endtask

  task automatic t_debounce_and_fail();
    int n;
    in_ok = 0;
    wait_cyc(DEB - 1);
    in_ok = 1;
    wait_cyc(SETTLE);
    check("R9 short pulse ignored", outs(), 7);
    wd_req = 1;
    in_hi = 0; in_lo = 0; in_ok = 0;
    count_until(1, 1'b0, 100, n);
    check("R9 fail latency", n, DEB + 3);
    check("R7 fail with wd request", outs(), 0);
    wd_req = 0;
    wait_cyc(5);
    check("R7 reset held after wd request ends", outs(), 0);
    in_lo = 1; in_ok = 1;
    wait_cyc(SETTLE);
    check("R7 still held without high flag", outs(), 0);
    in_hi = 1;
    count_until(1, 1'b1, 100, n);
    check("R7 new sequence starts", n, DEB + 3);
    count_until(0, 1'b1, TIMEOUT + 50, n);
    check("R7 full delay repeated", n, TIMEOUT);
  endtask

  task automatic t_supply_loss();
    int n;
    sup_on = 0; sup_hold = 0;
    wait_cyc(SETTLE);
    check("R8 supply loss clears outputs", outs(), 0);
    sup_hold = 1;
    wait_cyc(SETTLE);
    check("R8 off flag back alone", outs(), 0);
    in_hi = 0; in_lo = 0; in_ok = 0;
    sup_on = 1;
    wait_cyc(SETTLE);
    check("R2 supply on, input low", outs(), 0);
    in_hi = 1; in_lo = 1; in_ok = 1;
    count_until(1, 1'b1, 100, n);
    check("R2 save rise latency, input last", n, DEB + 3);
    count_until(0, 1'b1, TIMEOUT + 50, n);
    check("R3 delay length, input last", n, TIMEOUT);
  endtask

  initial begin
    rst_n = 0; sup_on = 0; sup_hold = 0; in_hi = 0; in_lo = 0; in_ok = 0; wd_req = 0;
    wait_cyc(4);
    rst_n = 1;
    wait_cyc(2);
    t_reset_state();
    t_powerup_supply_last();
    t_wd_request();
    t_low_dip();
    t_debounce_and_fail();
    t_supply_loss();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule